// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block adds a second, full-date alarm to a real-time clock and lets a match on it switch the system off. Six BCD alarm registers (seconds, minutes, hours, day, month, year) are compared with the running calendar fields each time the calendar's one-second update strobe fires. If the alarm event is enabled, a match latches a status flag that raises an interrupt. If software has also handed the power-enable pin to this logic, the same match drives the pin low so that an external power management device turns the supply off.

The calendar counter and the power device are outside the block. The calendar supplies its current BCD fields and the one-second strobe. Software reaches the alarm, control and status registers through a simple write port and a combinational read port. A write that lands in the same cycle as the strobe is not seen by that strobe. Software therefore programs the alarm at least two seconds ahead of the time it targets.

Top module: `pwr_alarm_ctrl`

## Requirements
- R1: After reset, power_en is 1, irq is 0 and every register index reads 0.
- R2: Register indices 0 to 5 hold the alarm fields seconds, minutes, hours, day, month and year. Each is 8 bits wide and reads back what was last written. Index 6 is control: bit 0 hands the pin to the alarm logic and bit 1 enables the alarm event. Index 7 is status, with the alarm flag in bit 0.
- R3: A comparison takes place only in a cycle where tick_1s is 1. All six fields must be exactly equal. A difference in any one field produces no event.
- R4: With control bit 1 set, a match on a strobe sets the status flag from the next cycle. irq equals the flag ANDed with control bit 1.
- R5: Writing status with bit 0 at 1 clears the flag, and writing it with bit 0 at 0 leaves the flag unchanged. If a new match and a clearing write occur in the same cycle, the flag stays set.
- R6: With control bit 1 clear, a match sets no flag and does not change power_en.
- R7: While control bit 0 is clear, power_en is 1 whatever the alarm state.
- R8: With control bits 0 and 1 both set, a match drives power_en to 0 from the next cycle. It stays 0 while bit 0 stays set, even after the flag is cleared.
- R9: Clearing control bit 0 brings power_en back to 1 in the cycle after the write.
- R10: An alarm-field write in the same cycle as a strobe is not seen by that strobe. The compare uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-second calendar update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 8 | Register read data (combinational) |
| power_en | output | 1 | Power-enable pin, 1 = ON |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit fields, six fields and a 3-bit index. With these values the whole register space fits in eight indices and every one is read back after reset. The calendar fields are driven directly, not counted, so any date is reachable on demand. This makes single-field mismatches, same-cycle write and strobe collisions, and same-cycle set and clear of the flag easy to place exactly.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int unsigned IDX_CTRL = 6;
  localparam int unsigned IDX_STAT = 7;
  localparam int unsigned CTL_HANDOVER = 0;
  localparam int unsigned CTL_ALARM_EN = 1;
  localparam int unsigned STS_FLAG = 0;

  typedef enum logic {
    PWR_ON  = 1'b0,
    PWR_OFF = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pa_regs.sv
module pa_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 6,
  parameter int unsigned AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic             set_flag,
  output logic [NF*DW-1:0] alarm_flat,
  output logic             handover,
  output logic             alarm_en,
  output logic             flag,
  output logic [DW-1:0]    rd_data
);
  import pa_pkg::*;

  localparam int unsigned NREG = 1 << AW;

  for (genvar i = 0; i < NF; i++) begin : g_field
    logic [DW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_en && (wr_addr == AW'(i)))
        val_q <= wr_data;
    end
    assign alarm_flat[i*DW +: DW] = val_q;
  end

  wire ctl_wr = wr_en && (wr_addr == AW'(IDX_CTRL));
  wire sts_wr = wr_en && (wr_addr == AW'(IDX_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handover <= 1'b0;
      alarm_en <= 1'b0;
    end else if (ctl_wr) begin
      handover <= wr_data[CTL_HANDOVER];
      alarm_en <= wr_data[CTL_ALARM_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set_flag)
      flag <= 1'b1;
    else if (sts_wr && wr_data[STS_FLAG])
      flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(IDX_CTRL)) begin
      rd_data[CTL_HANDOVER] = handover;
      rd_data[CTL_ALARM_EN] = alarm_en;
    end else if (rd_addr == AW'(IDX_STAT)) begin
      rd_data[STS_FLAG] = flag;
    end else if (int'(rd_addr) < NF) begin
      rd_data = alarm_flat[int'(rd_addr)*DW +: DW];
    end
  end

  initial begin
    if (NREG < NF + 2) $error("pa_regs: index space too small");
  end
endmodule

// File: rtl/pa_match.sv
module pa_match #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 6
) (
  input  logic [NF*DW-1:0] alarm_flat,
  input  logic [NF*DW-1:0] now_flat,
  output logic             hit
);
  function automatic logic all_fields_equal(
    input logic [NF*DW-1:0] a,
    input logic [NF*DW-1:0] b
  );
    logic eq;
    eq = 1'b1;
    for (int k = 0; k < NF; k++)
      if (a[k*DW +: DW] != b[k*DW +: DW]) eq = 1'b0;
    return eq;
  endfunction

  assign hit = all_fields_equal(alarm_flat, now_flat);
endmodule

// File: rtl/pa_pwr_fsm.sv
module pa_pwr_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic handover,
  input  logic fire,
  output logic power_en
);
  import pa_pkg::*;

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!handover)
      state_d = PWR_ON;
    else if (fire)
      state_d = PWR_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PWR_ON;
    else        state_q <= state_d;
  end

  assign power_en = !((state_q == PWR_OFF) && handover);
endmodule

// File: rtl/pwr_alarm_ctrl.sv
module pwr_alarm_ctrl #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 6,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1s,
  input  logic [DW-1:0] now_sec,
  input  logic [DW-1:0] now_min,
  input  logic [DW-1:0] now_hour,
  input  logic [DW-1:0] now_day,
  input  logic [DW-1:0] now_mon,
  input  logic [DW-1:0] now_year,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          power_en,
  output logic          irq
);
  logic [NF*DW-1:0] alarm_flat;
  logic [NF*DW-1:0] now_flat;
  logic             handover;
  logic             alarm_en;
  logic             flag;
  logic             hit;
  logic             fire;

  assign now_flat = {now_year, now_mon, now_day, now_hour, now_min, now_sec};

  pa_regs #(.DW(DW), .NF(NF), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .set_flag(fire),
    .alarm_flat(alarm_flat), .handover(handover),
    .alarm_en(alarm_en), .flag(flag), .rd_data(rd_data)
  );

  pa_match #(.DW(DW), .NF(NF)) u_match (
    .alarm_flat(alarm_flat), .now_flat(now_flat), .hit(hit)
  );

  assign fire = tick_1s && hit && alarm_en;

  pa_pwr_fsm u_pwr (
    .clk(clk), .rst_n(rst_n),
    .handover(handover), .fire(fire), .power_en(power_en)
  );

  assign irq = flag && alarm_en;
endmodule

// File: rtl/pa_checker.sv
module pa_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic hit,
  input logic alarm_en,
  input logic handover,
  input logic flag,
  input logic irq,
  input logic power_en
);
  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && hit && alarm_en)); // R3

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R4

  AST_PIN_HIGH_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !handover |-> power_en); // R7

  AST_OFF_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_en) |-> $past(tick && hit && alarm_en)); // R6

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!power_en) && $past(handover) && handover) |-> !power_en); // R8
endmodule

bind pwr_alarm_ctrl pa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_1s), .hit(hit),
  .alarm_en(alarm_en), .handover(handover), .flag(flag),
  .irq(irq), .power_en(power_en)
);

// File: tb/pwr_alarm_ctrl_tb.sv
module pwr_alarm_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1s = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [7:0] now_day = '0, now_mon = '0, now_year = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic power_en, irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_alarm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .power_en(power_en), .irq(irq)
  );

  // behavioural reference model
  int m_alarm[6];
  bit m_ho, m_en, m_flag, m_off;

  function automatic int now_field(int k);
    case (k)
      0: return int'(now_sec);
      1: return int'(now_min);
      2: return int'(now_hour);
      3: return int'(now_day);
      4: return int'(now_mon);
      default: return int'(now_year);
    endcase
  endfunction

  function automatic int model_read(int a);
    if (a < 6) return m_alarm[a];
    if (a == 6) return (m_en ? 2 : 0) + (m_ho ? 1 : 0);
    return m_flag ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_alarm[k]) m_alarm[k] = 0;
      m_ho = 0; m_en = 0; m_flag = 0; m_off = 0;
    end else begin
      bit same, ev;
      same = 1;
      for (int k = 0; k < 6; k++) if (m_alarm[k] != now_field(k)) same = 0;
      ev = tick_1s && same && m_en;
      if (!m_ho) m_off = 0;
      else if (ev) m_off = 1;
      if (ev) m_flag = 1;
      else if (wr_en && wr_addr == 3'd7 && wr_data[0]) m_flag = 0;
      if (wr_en) begin
        if (wr_addr < 3'd6) m_alarm[int'(wr_addr)] = int'(wr_data);
        else if (wr_addr == 3'd6) begin
          m_ho = wr_data[0];
          m_en = wr_data[1];
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R8 model power_en", int'(power_en), (m_off && m_ho) ? 0 : 1);
      check("R4 model irq", int'(irq), (m_flag && m_en) ? 1 : 0);
      check("R2 model rd_data", int'(rd_data), model_read(int'(rd_addr)));
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    tick_1s = 1'b0;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    step();
  endtask

  task automatic rd(string tag, int a, int exp);
    rd_addr = 3'(a);
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic set_now(int s, int mi, int h, int d, int mo, int y);
    now_sec = 8'(s); now_min = 8'(mi); now_hour = 8'(h);
    now_day = 8'(d); now_mon = 8'(mo); now_year = 8'(y);
  endtask

  task automatic tick();
    tick_1s = 1'b1;
    step();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset power_en", int'(power_en), 1);
    check("R1 reset irq", int'(irq), 0);
    for (int a = 0; a < 8; a++) rd("R1 reset regs", a, 0);

    // program alarm 12:34:56 day 15 month 06 year 24
    wr(0, 'h56); wr(1, 'h34); wr(2, 'h12); wr(3, 'h15); wr(4, 'h06); wr(5, 'h24);
    rd("R2 seconds", 0, 'h56);
    rd("R2 year", 5, 'h24);
    rd("R2 day", 3, 'h15);

    wr(6, 2);
    rd("R2 control", 6, 2);
    set_now('h56, 'h34, 'h12, 'h15, 'h06, 'h24);
    step(); step();
    rd("R3 no flag without tick", 7, 0);
    set_now('h56, 'h34, 'h12, 'h15, 'h06, 'h25);
    tick();
    rd("R3 year mismatch", 7, 0);
    set_now('h56, 'h34, 'h12, 'h16, 'h06, 'h24);
    tick();
    rd("R3 day mismatch", 7, 0);
    set_now('h56, 'h34, 'h12, 'h15, 'h06, 'h24);
    tick();
    rd("R4 flag set", 7, 1);
    check("R4 irq raised", int'(irq), 1);
    check("R7 pin not handed over", int'(power_en), 1);

    wr(7, 0);
    rd("R5 write 0 keeps flag", 7, 1);
    wr(7, 1);
    rd("R5 write 1 clears flag", 7, 0);
    check("R5 irq cleared", int'(irq), 0);

    wr(6, 1);
    tick();
    rd("R6 disabled no flag", 7, 0);
    check("R6 disabled pin high", int'(power_en), 1);

    wr(6, 3);
    tick();
    check("R8 pin off", int'(power_en), 0);
    wr(7, 1);
    check("R8 pin stays off after clear", int'(power_en), 0);
    step(); step();
    check("R8 pin still off", int'(power_en), 0);

    wr(6, 2);
    check("R9 release", int'(power_en), 1);
    wr(7, 1);

    // R10: write and tick in the same cycle
    wr(6, 3);
    set_now('h57, 'h34, 'h12, 'h15, 'h06, 'h24);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h57;
    tick();
    check("R10 same-cycle write unseen", int'(power_en), 1);
    rd("R10 no flag", 7, 0);
    tick();
    check("R10 later tick fires", int'(power_en), 0);

    // R5: set and clear in the same cycle
    wr(6, 2);
    wr(7, 1);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h01;
    tick();
    rd("R5 set wins", 7, 1);

    step();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule